// File: doc/BRIEF.md
# TRS Word-Alignment Framer

This block finds the character boundary in a stream of unaligned 10-bit words coming from a deserializer. The deserializer cuts the serial bit stream into words at an arbitrary phase. The framer looks for a 30-bit timing-reference preamble at every one of the ten possible bit phases, across a window built from the incoming word and the three words before it. When it finds the preamble it locks to that phase. It then sends out re-aligned 10-bit characters through a barrel selector.

Once locked, a preamble at the locked phase confirms sync. A preamble at a different phase is handled according to the sync-enable input. When sync-enable is high the framer moves to the new phase at once. When it is low the framer keeps its phase and flags a sync error. Descrambling and decoding of the payload are done elsewhere.

Top module: `trs_framer`

## Requirements
- R1: While reset is asserted and right after it, `valid_o`, `sync_o` and `err_o` are low and `data_o` is zero. The framer starts unlocked with phase 0.
- R2: Bit order and preamble. Bit 0 of each input word is the earliest bit in the stream. The preamble is ten consecutive 1 bits followed by twenty consecutive 0 bits in stream order. It is recognised at any bit phase 0 to 9, and a given window can match at only one phase.
- R3: When unlocked, the framer adopts the phase of the first preamble it detects, whatever the level of `sync_en_i`. It pulses `sync_o` for one output word.
- R4: Each output follows its input by one clock. `valid_o` equals `valid_i` from the previous clock. The word flagged by `sync_o` is the last all-zero word of the preamble (0x000). The words after it are the aligned stream words, in order and with none missing.
- R5: A preamble at the locked phase pulses `sync_o` and leaves the phase unchanged.
- R6: A preamble at another phase while `sync_en_i` is high moves the framer to the new phase. That output word is already aligned to the new phase and carries a `sync_o` pulse.
- R7: A preamble at another phase while `sync_en_i` is low keeps the old phase. It pulses `err_o` for one word, with `sync_o` low.
- R8: A clock with `valid_i` low does not shift the search window. It gives `valid_o` low, with `sync_o` and `err_o` low. A preamble split by such gaps is still found.
- R9: `sync_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| data_i | input | 10 | Unaligned input word, bit 0 earliest |
| sync_en_i | input | 1 | Allow re-framing to a new phase while locked |
| valid_o | output | 1 | Output word strobe |
| data_o | output | 10 | Aligned output word |
| sync_o | output | 1 | One-word pulse on the word that completes a preamble at the locked phase |
| err_o | output | 1 | One-word pulse when a preamble shows up at a foreign phase and re-framing is off |

## Verification
The assertions check these properties on every cycle:
- at most one phase matches per window;
- sync and error pulses are exclusive;
- both pulses stay quiet when no word is valid;
- the phase holds across an error;
- a sync leaves the framer locked;
- an enabled re-frame lands on the detected phase.

Only the bench scenarios can show the following:
- the preamble is found at several phases;
- the aligned payload after a sync comes out in the right order;
- the framer returns to its kept phase after a rejected preamble;
- detection works when the stream is broken up by invalid clocks.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int unsigned CHAR_W_DEF = 10;
  // preamble spans ones-word + two zero-words; window adds one word of slack
  localparam int unsigned PRE_WORDS  = 3;
  localparam int unsigned WIN_WORDS  = PRE_WORDS + 1;
endpackage

// File: rtl/trs_window.sv
module trs_window #(
  parameter int unsigned W = trs_pkg::CHAR_W_DEF,
  localparam int unsigned WIN_W = W * trs_pkg::WIN_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W-1:0]     data_i,
  output logic [WIN_W-1:0] win_o
);
  localparam int unsigned HIST = trs_pkg::WIN_WORDS - 1;

  logic [W-1:0] hist_q [HIST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else if (valid_i) begin
      hist_q[0] <= data_i;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // oldest word in the low bits: win_o[0] is earliest stream bit
  assign win_o[WIN_W-1 -: W] = data_i;
  for (genvar i = 0; i < HIST; i++) begin : g_win
    assign win_o[(HIST-1-i)*W +: W] = hist_q[i];
  end
endmodule

// File: rtl/trs_match.sv
module trs_match #(
  parameter int unsigned W = trs_pkg::CHAR_W_DEF,
  localparam int unsigned WIN_W = W * trs_pkg::WIN_WORDS,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic [WIN_W-1:0] win_i,
  output logic [W-1:0]     hit_o,
  output logic             hit_any_o,
  output logic [OFF_W-1:0] hit_off_o
);
  for (genvar k = 0; k < W; k++) begin : g_phase
    assign hit_o[k] = (&win_i[k +: W]) && ~(|win_i[k+W +: 2*W]);
  end

  assign hit_any_o = |hit_o;

  always_comb begin
    hit_off_o = '0;
    for (int k = 0; k < W; k++) begin
      if (hit_o[k]) hit_off_o = OFF_W'(k);
    end
  end
endmodule

// File: rtl/trs_barrel.sv
module trs_barrel #(
  parameter int unsigned W = trs_pkg::CHAR_W_DEF,
  localparam int unsigned WIN_W = W * trs_pkg::WIN_WORDS,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]     char_o
);
  logic [W-1:0] cand [W];

  // newest fully received word at phase k ends at bit k+3W-1
  for (genvar k = 0; k < W; k++) begin : g_cand
    assign cand[k] = win_i[k + 2*W +: W];
  end

  always_comb begin
    char_o = '0;
    for (int k = 0; k < W; k++) begin
      if (off_i == OFF_W'(k)) char_o = cand[k];
    end
  end
endmodule

// File: rtl/trs_lock_ctrl.sv
module trs_lock_ctrl #(
  parameter int unsigned W = trs_pkg::CHAR_W_DEF,
  localparam int unsigned OFF_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sync_en_i,
  input  logic             hit_any_i,
  input  logic [OFF_W-1:0] hit_off_i,
  output logic [OFF_W-1:0] off_o,
  output logic             sync_o,
  output logic             err_o
);
  logic             locked_q, locked_d;
  logic [OFF_W-1:0] off_q;

  always_comb begin
    off_o    = off_q;
    locked_d = locked_q;
    sync_o   = 1'b0;
    err_o    = 1'b0;
    if (valid_i && hit_any_i) begin
      if (!locked_q || hit_off_i == off_q || sync_en_i) begin
        off_o    = hit_off_i;
        locked_d = 1'b1;
        sync_o   = 1'b1;
      end else begin
        err_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      off_q    <= '0;
    end else begin
      locked_q <= locked_d;
      off_q    <= off_o;
    end
  end

  // R7: foreign preamble with re-framing off keeps the phase
  a_r7_err_keeps_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(off_q));

  // R3: any sync leaves the framer locked
  a_r3_sync_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> locked_q);

  // R6: enabled re-frame lands on the detected phase
  a_r6_relock_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_any_i && sync_en_i) |=> (off_q == $past(hit_off_i)));
endmodule

// File: rtl/trs_framer.sv
module trs_framer #(
  parameter int unsigned CHAR_W = trs_pkg::CHAR_W_DEF,
  localparam int unsigned WIN_W = CHAR_W * trs_pkg::WIN_WORDS,
  localparam int unsigned OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              sync_en_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              sync_o,
  output logic              err_o
);
  logic [WIN_W-1:0]  win;
  logic [CHAR_W-1:0] hit;
  logic              hit_any;
  logic [OFF_W-1:0]  hit_off, off;
  logic              sync_d, err_d;
  logic [CHAR_W-1:0] aligned;

  trs_window #(.W(CHAR_W)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i), .win_o(win)
  );

  trs_match #(.W(CHAR_W)) u_match (
    .win_i(win), .hit_o(hit), .hit_any_o(hit_any), .hit_off_o(hit_off)
  );

  trs_lock_ctrl #(.W(CHAR_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sync_en_i(sync_en_i),
    .hit_any_i(hit_any), .hit_off_i(hit_off),
    .off_o(off), .sync_o(sync_d), .err_o(err_d)
  );

  trs_barrel #(.W(CHAR_W)) u_barrel (
    .win_i(win), .off_i(off), .char_o(aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sync_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sync_o  <= sync_d;
      err_o   <= err_d;
      if (valid_i) data_o <= aligned;
    end
  end

  // R2: a window matches at one phase at most
  a_r2_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot0(hit));

  // R9: pulses are exclusive
  a_r9_sync_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_o && err_o));

  // R8: no pulse without a valid word
  a_r8_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!sync_o && !err_o));
endmodule

// File: tb/trs_framer_tb_top.sv
module trs_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       valid_i;
  logic [9:0] data_i;
  logic       sync_en_i;
  logic       valid_o;
  logic [9:0] data_o;
  logic       sync_o;
  logic       err_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic       sbits [4096];
  int         slen;
  logic [9:0] od [1024];
  logic       os [1024];
  logic       oe [1024];
  int         n_out;
  logic       prev_v;

  always #2 clk = ~clk;

  trs_framer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .sync_en_i(sync_en_i), .valid_o(valid_o), .data_o(data_o),
    .sync_o(sync_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pay(input int j, input int i);
    logic [9:0] x;
    x = 10'((j * 5 + i * 3 + 1) * 91) ^ 10'h155;
    return (x | 10'h021) & 10'h1FF;  // bit9 clear, bits 0/5 set: no false preamble
  endfunction

  task automatic capture();
    check(valid_o == prev_v, "R4 valid follows input", valid_o, prev_v);
    check(!(sync_o && err_o), "R9 exclusive pulses", {sync_o, err_o}, 0);
    if (!valid_o) check(!sync_o && !err_o, "R8 idle quiet", {sync_o, err_o}, 0);
    if (valid_o && n_out < 1024) begin
      od[n_out] = data_o;
      os[n_out] = sync_o;
      oe[n_out] = err_o;
      n_out++;
    end
  endtask

  task automatic step(input logic v, input logic [9:0] d);
    @(negedge clk);
    capture();
    valid_i = v;
    data_i  = d;
    prev_v  = v;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; data_i = '0; sync_en_i = 1'b0;
    prev_v = 1'b0; n_out = 0; slen = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic add_bits(input logic [9:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sbits[slen] = v[i % 10];
      slen++;
    end
  endtask

  task automatic add_frame(input int j);
    add_bits(10'h3FF, 10);
    add_bits(10'h000, 10);
    add_bits(10'h000, 10);
    for (int i = 0; i < 4; i++) add_bits(pay(j, i), 10);
  endtask

  task automatic send_stream(input bit gaps);
    int nw;
    logic [9:0] c;
    nw = (slen + 9) / 10;
    for (int w = 0; w < nw; w++) begin
      for (int b = 0; b < 10; b++) c[b] = (w * 10 + b < slen) ? sbits[w * 10 + b] : 1'b0;
      step(1'b1, c);
      if (gaps) step(1'b0, 10'h3FF);  // junk on an invalid clock
    end
    repeat (3) step(1'b0, 10'h000);
  endtask

  function automatic int nth_event(input bit is_err, input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n_out; i++) begin
      if ((is_err ? oe[i] : os[i]) == 1'b1) begin
        if (cnt == n) return i;
        cnt++;
      end
    end
    return -1;
  endfunction

  function automatic int count_events(input bit is_err);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n_out; i++) if ((is_err ? oe[i] : os[i]) == 1'b1) cnt++;
    return cnt;
  endfunction

  task automatic verify_frame(input int n, input int j, input string req);
    int idx;
    idx = nth_event(1'b0, n);
    check(idx >= 0, req, idx, 0);
    if (idx >= 0) begin
      check(od[idx] == 10'h000, req, od[idx], 0);
      for (int i = 0; i < 4; i++)
        check(idx + 1 + i < n_out && od[idx + 1 + i] == pay(j, i), req,
              od[idx + 1 + i], pay(j, i));
    end
  endtask

  // R1
  task automatic t_reset();
    rst_ni = 1'b0; valid_i = 1'b0; data_i = 10'h3FF; sync_en_i = 1'b1;
    @(negedge clk);
    check(!valid_o && !sync_o && !err_o && data_o == 0, "R1 in reset",
          {valid_o, sync_o, err_o, data_o}, 0);
    do_reset();
    @(negedge clk);
    check(!valid_o && !sync_o && !err_o && data_o == 0, "R1 after reset",
          {valid_o, sync_o, err_o, data_o}, 0);
    prev_v = 1'b0;
  endtask

  // R2 R3 R4 (R8 with gaps)
  task automatic t_lock(input int s, input bit gaps);
    do_reset();
    add_bits(10'h000, 10); add_bits(10'h000, 10 + s);
    add_frame(0);
    add_bits(10'h000, 10); add_bits(10'h000, 10);
    send_stream(gaps);
    check(count_events(1'b0) == 1, gaps ? "R8 sync through gaps" : "R3 one sync",
          count_events(1'b0), 1);
    check(count_events(1'b1) == 0, "R3 no error", count_events(1'b1), 0);
    verify_frame(0, 0, gaps ? "R8 aligned through gaps" : "R2/R4 aligned payload");
  endtask

  // R5
  task automatic t_same();
    do_reset();
    add_bits(10'h000, 10); add_bits(10'h000, 14);
    add_frame(0);
    add_bits(10'h000, 10); add_bits(10'h000, 10);
    add_frame(1);
    add_bits(10'h000, 10); add_bits(10'h000, 10);
    send_stream(1'b0);
    check(count_events(1'b0) == 2, "R5 two syncs", count_events(1'b0), 2);
    check(count_events(1'b1) == 0, "R5 no error", count_events(1'b1), 0);
    verify_frame(0, 0, "R5 first frame");
    verify_frame(1, 1, "R5 second frame");
  endtask

  // R6 / R7
  task automatic t_shift(input bit en);
    do_reset();
    sync_en_i = en;
    add_bits(10'h000, 10); add_bits(10'h000, 12);
    add_frame(0);
    add_bits(10'h000, 10); add_bits(10'h000, 13);   // phase +3
    add_frame(1);
    add_bits(10'h000, 10); add_bits(10'h000, 17);   // phase back to original
    add_frame(2);
    add_bits(10'h000, 10); add_bits(10'h000, 10);
    send_stream(1'b0);
    if (en) begin
      check(count_events(1'b0) == 3, "R6 three syncs", count_events(1'b0), 3);
      check(count_events(1'b1) == 0, "R6 no error", count_events(1'b1), 0);
      verify_frame(0, 0, "R6 frame0");
      verify_frame(1, 1, "R6 reframed frame1");
      verify_frame(2, 2, "R6 reframed frame2");
    end else begin
      check(count_events(1'b0) == 2, "R7 two syncs", count_events(1'b0), 2);
      check(count_events(1'b1) == 1, "R7 one error", count_events(1'b1), 1);
      check(nth_event(1'b1, 0) > nth_event(1'b0, 0) && nth_event(1'b1, 0) < nth_event(1'b0, 1),
            "R7 error between syncs", nth_event(1'b1, 0), 0);
      verify_frame(0, 0, "R7 frame0");
      verify_frame(1, 2, "R7 kept phase frame2");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    valid_i = 1'b0; data_i = '0; sync_en_i = 1'b0; rst_ni = 1'b0; prev_v = 1'b0;
    n_out = 0; slen = 0;
    t_reset();
    t_lock(0, 1'b0);
    t_lock(3, 1'b0);
    t_lock(9, 1'b0);
    t_same();
    t_shift(1'b1);
    t_shift(1'b0);
    t_lock(7, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule